// File: doc/BRIEF.md
# Banked Scratchpad Conflict Serializer

This block serves one warp-wide scratchpad access at a time. A request carries up to 32 lanes. Each lane has an enable bit, a word address and, when the request is a store, a 32-bit data word. The storage is spread over 32 single-port banks. Each bank can perform one row access per clock. The block works out which bank every active lane hits. It then issues the request as a series of conflict-free passes, one per clock, until every active lane has been served. After the last pass it raises a one-cycle completion strobe. The strobe comes with the per-lane load results and the number of passes the request needed.

In each pass, every bank serves exactly one of its pending rows. Any number of lanes that want that same row are served together. A request in which all lanes hit one word, or in which every lane hits its own bank, therefore finishes in a single pass. A request in which several distinct words share a bank takes as many passes as the busiest bank has distinct words. A mode input widens the bank word from 4 to 8 bytes. Two 4-byte words that sit in the same 8-byte bank word then cost only one access. The requester sees a ready/valid handshake, and no new request is taken while passes remain.

Top module: `scratch_bank_serializer`

## Requirements
- R1: In 4-byte mode a lane's bank is its word address modulo 32, its row is address bits [8:5], and address bit 9 is ignored. Active lanes that all hit different banks complete in one pass.
- R2: The pass count of a request is the largest number of distinct words that its active lanes want from any single bank. done_o is first seen high after the max(P,1)-th rising edge that follows the accepting edge, where P is the pass count.
- R3: Lanes that address the same word share that bank's single access in one pass. If every lane reads one word, the request takes one pass.
- R4: In 8-byte mode (wide_mode_i=1) the bank is address bits [5:1], the row is bits [9:6] and bit 0 selects the upper (1) or lower (0) 4-byte half. Two lanes that differ only in bit 0 share one access.
- R5: Inactive lanes are left out of conflict detection and return zero read data.
- R6: When several lanes of a store address the same 4-byte location, the lane with the highest index is the one written. A store request returns zero read data on all lanes.
- R7: req_ready_o is high only while idle. A request is taken on a rising edge with req_valid_i and req_ready_o both high. Ready stays low until the final pass. done_o is high for exactly one cycle, and ready is high in that cycle.
- R8: A request with no active lanes completes after one cycle with a pass count of 0.
- R9: After reset, req_ready_o is 1, done_o is 0, rsp_passes_o is 0 and rsp_rdata_o is all zero.
- R10: A load returns, on each active lane, the value most recently stored to the same 4-byte location. 4-byte-mode address a and 8-byte-mode address 2a (mod 1024) name the same location.
- R11: rsp_passes_o gives the pass count of the last completed request and holds it until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wide_mode_i | input | 1 | 1 selects 8-byte bank words, sampled on accept |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Block idle and able to take a request |
| req_store_i | input | 1 | 1 for a store request, 0 for a load |
| req_active_i | input | LANES (32) | Per-lane enable |
| req_addr_i | input | LANES*ADDR_W (320) | Per-lane word address, lane l at [l*10 +: 10] |
| req_wdata_i | input | LANES*DATA_W (1024) | Per-lane store data, lane l at [l*32 +: 32] |
| done_o | output | 1 | One-cycle completion strobe |
| rsp_rdata_o | output | LANES*DATA_W (1024) | Per-lane load results, lane l at [l*32 +: 32] |
| rsp_passes_o | output | CNT_W (6) | Passes taken by the last request |

## Verification
The bound checker watches the properties that hold on every cycle. Ready drops after each accept and is high when done_o fires. done_o lasts a single cycle. Inactive lanes and store responses carry zero data. The reported pass count never exceeds the number of active lanes and is nonzero whenever a lane was active. The busy time always equals max(pass count, 1). The checker cannot tell which pass count is correct for a given address pattern, whether read data is right, or which store lane wins a shared word. Only the bench's scenarios show those. It runs bank-strided, broadcast, half-word-paired and aliasing address patterns in both modes against a location model.

// File: rtl/scs_pkg.sv
package scs_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } scs_state_e;

  // busy time of a request: one cycle even when no lane is active
  function automatic int unsigned scs_busy_cycles(int unsigned passes);
    return (passes == 0) ? 1 : passes;
  endfunction

endpackage

// File: rtl/scs_lane_map.sv
module scs_lane_map #(
  parameter int LANES  = 32,
  parameter int ADDR_W = 10,
  parameter int BANK_W = 5,
  parameter int ROW_W  = 4
) (
  input  logic                    wide_i,
  input  logic [LANES*ADDR_W-1:0] addr_i,
  output logic [LANES*BANK_W-1:0] bank_o,
  output logic [LANES*ROW_W-1:0]  row_o,
  output logic [LANES-1:0]        half_o
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [ADDR_W-1:0] a;
    assign a = addr_i[l*ADDR_W +: ADDR_W];
    // wide mode drops bit 0 into the half select
    assign bank_o[l*BANK_W +: BANK_W] = wide_i ? a[BANK_W:1] : a[BANK_W-1:0];
    assign row_o[l*ROW_W +: ROW_W]    = wide_i ? a[BANK_W+ROW_W:BANK_W+1]
                                               : a[BANK_W+ROW_W-1:BANK_W];
    assign half_o[l] = wide_i & a[0];
  end

endmodule

// File: rtl/scs_arbiter.sv
module scs_arbiter #(
  parameter int LANES  = 32,
  parameter int BANKS  = 32,
  parameter int BANK_W = 5,
  parameter int ROW_W  = 4
) (
  input  logic [LANES-1:0]        pending_i,
  input  logic [LANES*BANK_W-1:0] bank_i,
  input  logic [LANES*ROW_W-1:0]  row_i,
  output logic [LANES-1:0]        grant_o,
  output logic [BANKS*ROW_W-1:0]  sel_row_o
);

  // per bank: row of the lowest pending lane that targets it
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [ROW_W-1:0] row_pick;
    always_comb begin
      row_pick = '0;
      for (int l = LANES - 1; l >= 0; l--) begin
        if (pending_i[l] && (bank_i[l*BANK_W +: BANK_W] == BANK_W'(b))) begin
          row_pick = row_i[l*ROW_W +: ROW_W];
        end
      end
    end
    assign sel_row_o[b*ROW_W +: ROW_W] = row_pick;
  end

  // every pending lane wanting the chosen row of its bank rides along
  for (genvar l = 0; l < LANES; l++) begin : g_grant
    logic [BANK_W-1:0] bk;
    assign bk = bank_i[l*BANK_W +: BANK_W];
    assign grant_o[l] = pending_i[l] &&
                        (row_i[l*ROW_W +: ROW_W] == sel_row_o[bk*ROW_W +: ROW_W]);
  end

endmodule

// File: rtl/scs_bank.sv
module scs_bank #(
  parameter int LANES  = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int ROW_W  = 4
) (
  input  logic                    clk_i,
  input  logic                    store_i,
  input  logic [LANES-1:0]        hit_i,
  input  logic [LANES-1:0]        half_i,
  input  logic [LANES*DATA_W-1:0] wdata_i,
  input  logic [ROW_W-1:0]        row_i,
  output logic [2*DATA_W-1:0]     rdata_o
);

  logic [2*DATA_W-1:0] mem [DEPTH];
  logic [1:0]          we;
  logic [2*DATA_W-1:0] wd;

  // ascending scan: the highest hitting lane overwrites earlier ones
  always_comb begin
    we = '0;
    wd = '0;
    for (int l = 0; l < LANES; l++) begin
      if (store_i && hit_i[l]) begin
        if (half_i[l]) begin
          we[1] = 1'b1;
          wd[DATA_W +: DATA_W] = wdata_i[l*DATA_W +: DATA_W];
        end else begin
          we[0] = 1'b1;
          wd[0 +: DATA_W] = wdata_i[l*DATA_W +: DATA_W];
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (we[0]) mem[row_i][0 +: DATA_W] <= wd[0 +: DATA_W];
    if (we[1]) mem[row_i][DATA_W +: DATA_W] <= wd[DATA_W +: DATA_W];
  end

  assign rdata_o = mem[row_i];

endmodule

// File: rtl/scratch_bank_serializer.sv
module scratch_bank_serializer
  import scs_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int BANKS  = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = $clog2(BANKS) + $clog2(DEPTH) + 1,
  parameter int CNT_W  = $clog2(LANES + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wide_mode_i,
  input  logic                    req_valid_i,
  output logic                    req_ready_o,
  input  logic                    req_store_i,
  input  logic [LANES-1:0]        req_active_i,
  input  logic [LANES*ADDR_W-1:0] req_addr_i,
  input  logic [LANES*DATA_W-1:0] req_wdata_i,
  output logic                    done_o,
  output logic [LANES*DATA_W-1:0] rsp_rdata_o,
  output logic [CNT_W-1:0]        rsp_passes_o
);

  localparam int BANK_W = $clog2(BANKS);
  localparam int ROW_W  = $clog2(DEPTH);
  localparam int WORD_W = 2 * DATA_W;

  scs_state_e              state_q;
  logic [LANES-1:0]        pending_q;
  logic [LANES*ADDR_W-1:0] addr_q;
  logic [LANES*DATA_W-1:0] wdata_q;
  logic                    store_q;
  logic                    wide_q;
  logic [LANES*DATA_W-1:0] res_q;
  logic [CNT_W-1:0]        cnt_q;
  logic                    done_q;

  logic [LANES*BANK_W-1:0] lane_bank;
  logic [LANES*ROW_W-1:0]  lane_row;
  logic [LANES-1:0]        lane_half;
  logic [LANES-1:0]        grant;
  logic [LANES-1:0]        pending_nxt;
  logic [BANKS*ROW_W-1:0]  sel_row;
  logic [BANKS*LANES-1:0]  hit_flat;
  logic [BANKS*WORD_W-1:0] bank_rd;
  logic [LANES*DATA_W-1:0] lane_rd;

  assign req_ready_o = (state_q == ST_IDLE);

  scs_lane_map #(
    .LANES (LANES),
    .ADDR_W(ADDR_W),
    .BANK_W(BANK_W),
    .ROW_W (ROW_W)
  ) i_lane_map (
    .wide_i(wide_q),
    .addr_i(addr_q),
    .bank_o(lane_bank),
    .row_o (lane_row),
    .half_o(lane_half)
  );

  scs_arbiter #(
    .LANES (LANES),
    .BANKS (BANKS),
    .BANK_W(BANK_W),
    .ROW_W (ROW_W)
  ) i_arbiter (
    .pending_i(pending_q),
    .bank_i   (lane_bank),
    .row_i    (lane_row),
    .grant_o  (grant),
    .sel_row_o(sel_row)
  );

  assign pending_nxt = pending_q & ~grant;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    for (genvar l = 0; l < LANES; l++) begin : g_hit
      assign hit_flat[b*LANES + l] =
        grant[l] && (lane_bank[l*BANK_W +: BANK_W] == BANK_W'(b));
    end

    scs_bank #(
      .LANES (LANES),
      .DATA_W(DATA_W),
      .DEPTH (DEPTH),
      .ROW_W (ROW_W)
    ) i_bank (
      .clk_i  (clk_i),
      .store_i(store_q),
      .hit_i  (hit_flat[b*LANES +: LANES]),
      .half_i (lane_half),
      .wdata_i(wdata_q),
      .row_i  (sel_row[b*ROW_W +: ROW_W]),
      .rdata_o(bank_rd[b*WORD_W +: WORD_W])
    );
  end

  // per-lane read crossbar: bank word then half
  for (genvar l = 0; l < LANES; l++) begin : g_rd
    logic [BANK_W-1:0] bk;
    assign bk = lane_bank[l*BANK_W +: BANK_W];
    assign lane_rd[l*DATA_W +: DATA_W] = lane_half[l]
      ? bank_rd[bk*WORD_W + DATA_W +: DATA_W]
      : bank_rd[bk*WORD_W +: DATA_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      pending_q <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      store_q   <= 1'b0;
      wide_q    <= 1'b0;
      res_q     <= '0;
      cnt_q     <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            state_q   <= ST_BUSY;
            pending_q <= req_active_i;
            addr_q    <= req_addr_i;
            wdata_q   <= req_wdata_i;
            store_q   <= req_store_i;
            wide_q    <= wide_mode_i;
            res_q     <= '0;
            cnt_q     <= '0;
          end
        end
        ST_BUSY: begin
          pending_q <= pending_nxt;
          if (|pending_q) cnt_q <= cnt_q + CNT_W'(1);
          for (int l = 0; l < LANES; l++) begin
            if (grant[l] && !store_q) begin
              res_q[l*DATA_W +: DATA_W] <= lane_rd[l*DATA_W +: DATA_W];
            end
          end
          if (pending_nxt == '0) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o       = done_q;
  assign rsp_rdata_o  = res_q;
  assign rsp_passes_o = cnt_q;

endmodule

// File: rtl/scs_checker.sv
module scs_checker
  import scs_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 6
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    req_valid_i,
  input logic                    req_ready_o,
  input logic                    req_store_i,
  input logic [LANES-1:0]        req_active_i,
  input logic                    done_o,
  input logic [LANES*DATA_W-1:0] rsp_rdata_o,
  input logic [CNT_W-1:0]        rsp_passes_o
);

  logic                    accept;
  logic [LANES-1:0]        act_q;
  logic                    st_q;
  logic [CNT_W-1:0]        busy_cnt;
  logic [LANES*DATA_W-1:0] lane_mask;

  assign accept = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q    <= '0;
      st_q     <= 1'b0;
      busy_cnt <= '0;
    end else if (accept) begin
      act_q    <= req_active_i;
      st_q     <= req_store_i;
      busy_cnt <= '0;
    end else if (!req_ready_o) begin
      busy_cnt <= busy_cnt + CNT_W'(1);
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_mask
    assign lane_mask[l*DATA_W +: DATA_W] = {DATA_W{act_q[l]}};
  end

  assert_busy_after_accept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !req_ready_o);

  assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_when_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> req_ready_o);

  assert_inactive_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((rsp_rdata_o & ~lane_mask) == '0));

  assert_store_no_data_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && st_q) |-> (rsp_rdata_o == '0));

  assert_pass_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (int'(rsp_passes_o) <= $countones(act_q)));

  assert_pass_nonzero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (act_q != '0)) |-> (rsp_passes_o != '0));

  assert_empty_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (act_q == '0)) |-> (rsp_passes_o == '0));

  assert_busy_matches_passes_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (int'(busy_cnt) == int'(scs_busy_cycles(int'(rsp_passes_o)))));

endmodule

bind scratch_bank_serializer scs_checker #(
  .LANES (LANES),
  .DATA_W(DATA_W),
  .CNT_W (CNT_W)
) i_scs_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_store_i (req_store_i),
  .req_active_i(req_active_i),
  .done_o      (done_o),
  .rsp_rdata_o (rsp_rdata_o),
  .rsp_passes_o(rsp_passes_o)
);

// File: tb/test_scratch_bank_serializer.sv
`timescale 1ns/1ps
module test_scratch_bank_serializer;

  localparam int LANES  = 32;
  localparam int DATA_W = 32;
  localparam int AW     = 10;
  localparam int CNT_W  = 6;
  localparam int NV     = 17;

  // {wide, store, mask[31:0], base[9:0], stride[9:0], period[5:0], passes[5:0]}
  localparam logic [65:0] VECS [NV] = '{
    {1'b0, 1'b0, 32'hFFFF_FFFF, 10'd0,   10'd1,  6'd32, 6'd1},
    {1'b0, 1'b0, 32'hFFFF_FFFF, 10'd5,   10'd0,  6'd32, 6'd1},
    {1'b0, 1'b0, 32'hFFFF_FFFF, 10'd3,   10'd32, 6'd8,  6'd8},
    {1'b0, 1'b0, 32'hFFFF_FFFF, 10'd0,   10'd2,  6'd32, 6'd2},
    {1'b1, 1'b0, 32'hFFFF_FFFF, 10'd0,   10'd2,  6'd32, 6'd1},
    {1'b1, 1'b0, 32'hFFFF_FFFF, 10'd0,   10'd1,  6'd32, 6'd1},
    {1'b0, 1'b0, 32'hFFFF_FFFF, 10'd7,   10'd33, 6'd32, 6'd1},
    {1'b0, 1'b0, 32'h0000_FFFF, 10'd0,   10'd32, 6'd32, 6'd16},
    {1'b0, 1'b0, 32'hFFFF_FFFF, 10'd0,   10'd16, 6'd32, 6'd16},
    {1'b1, 1'b0, 32'hFFFF_FFFF, 10'd1,   10'd64, 6'd4,  6'd4},
    {1'b0, 1'b1, 32'hFFFF_FFFF, 10'd40,  10'd0,  6'd32, 6'd1},
    {1'b0, 1'b0, 32'hFFFF_FFFF, 10'd40,  10'd0,  6'd32, 6'd1},
    {1'b0, 1'b1, 32'hAAAA_AAAA, 10'd100, 10'd32, 6'd4,  6'd2},
    {1'b0, 1'b0, 32'hFFFF_FFFF, 10'd100, 10'd32, 6'd4,  6'd4},
    {1'b1, 1'b1, 32'hFFFF_FFFF, 10'd200, 10'd1,  6'd32, 6'd1},
    {1'b0, 1'b0, 32'hFFFF_FFFF, 10'd100, 10'd1,  6'd32, 6'd1},
    {1'b1, 1'b0, 32'h0F0F_0F0F, 10'd300, 10'd64, 6'd32, 6'd8}
  };

  logic                    clk = 1'b0;
  logic                    rst_n;
  logic                    wide_v;
  logic                    valid_v;
  logic                    ready_o;
  logic                    store_v;
  logic [LANES-1:0]        mask_v;
  logic [LANES*AW-1:0]     addr_v;
  logic [LANES*DATA_W-1:0] wdata_v;
  logic                    done_o;
  logic [LANES*DATA_W-1:0] rdata_o;
  logic [CNT_W-1:0]        passes_o;

  logic [DATA_W-1:0] model [1024];
  int checks = 0;
  int errors = 0;
  int seq = 0;

  always #2.5 clk = ~clk;

  scratch_bank_serializer i_scratch_bank_serializer (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .wide_mode_i (wide_v),
    .req_valid_i (valid_v),
    .req_ready_o (ready_o),
    .req_store_i (store_v),
    .req_active_i(mask_v),
    .req_addr_i  (addr_v),
    .req_wdata_i (wdata_v),
    .done_o      (done_o),
    .rsp_rdata_o (rdata_o),
    .rsp_passes_o(passes_o)
  );

  task automatic chk(input logic c, input string rq, input string what,
                     input logic [63:0] got, input logic [63:0] exp_v);
    checks++;
    if (c !== 1'b1) begin
      errors++;
      $display("FAIL %s %s got %0h exp %0h", rq, what, got, exp_v);
    end
  endtask

  // storage location index of a 4-byte word (R10, R4)
  function automatic int loc_of(input logic wide, input logic [AW-1:0] a);
    return wide ? int'(a) : int'(a[8:0]) * 2;
  endfunction

  task automatic run_vec(input logic wide, input logic st, input logic [31:0] mask,
                         input int base, input int stride, input int period,
                         input int exp_p, input string rq);
    int cyc;
    int bad;
    int exp_lat;
    logic rdy_ok;
    logic [AW-1:0] a;
    logic [DATA_W-1:0] exp_d [LANES];
    logic [CNT_W-1:0] p_seen;
    string dtag;
    @(negedge clk);
    for (int l = 0; l < LANES; l++) begin
      a = AW'(base + (l % period) * stride);
      addr_v[l*AW +: AW] = a;
      wdata_v[l*DATA_W +: DATA_W] = DATA_W'(seq * 64 + l + 1) * 32'h9E37_79B9;
      exp_d[l] = (!st && mask[l]) ? model[loc_of(wide, a)] : '0;
    end
    wide_v  = wide;
    store_v = st;
    mask_v  = mask;
    valid_v = 1'b1;
    @(negedge clk);
    valid_v = 1'b0;
    cyc = 0;
    rdy_ok = 1'b1;
    while (!done_o && cyc < 200) begin
      if (ready_o) rdy_ok = 1'b0;
      @(negedge clk);
      cyc++;
    end
    exp_lat = (exp_p == 0) ? 1 : exp_p;
    chk(done_o, "R7", "done seen", 64'(done_o), 64'd1);
    chk(cyc == exp_lat, "R2", "latency", 64'(cyc), 64'(exp_lat));
    chk(int'(passes_o) == exp_p, rq, "pass count", 64'(passes_o), 64'(exp_p));
    chk(rdy_ok && ready_o, "R7", "ready low only while busy", 64'(rdy_ok), 64'd1);
    bad = -1;
    for (int l = 0; l < LANES; l++) begin
      if (bad < 0 && rdata_o[l*DATA_W +: DATA_W] !== exp_d[l]) bad = l;
    end
    if (bad >= 0 && !mask[bad]) dtag = "R5";
    else dtag = st ? "R6" : rq;
    if (bad < 0) chk(1'b1, dtag, "lane data", 64'd0, 64'd0);
    else chk(1'b0, dtag, $sformatf("lane %0d data", bad),
             64'(rdata_o[bad*DATA_W +: DATA_W]), 64'(exp_d[bad]));
    if (st) begin
      for (int l = 0; l < LANES; l++) begin
        if (mask[l]) model[loc_of(wide, addr_v[l*AW +: AW])] = wdata_v[l*DATA_W +: DATA_W];
      end
    end
    p_seen = passes_o;
    @(negedge clk);
    chk(!done_o, "R7", "done pulse width", 64'(done_o), 64'd0);
    chk(passes_o == p_seen, "R11", "pass count held", 64'(passes_o), 64'(p_seen));
    seq++;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog got timeout exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n   = 1'b0;
    wide_v  = 1'b0;
    valid_v = 1'b0;
    store_v = 1'b0;
    mask_v  = '0;
    addr_v  = '0;
    wdata_v = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    chk(ready_o, "R9", "ready after reset", 64'(ready_o), 64'd1);
    chk(!done_o, "R9", "done after reset", 64'(done_o), 64'd0);
    chk(passes_o == '0, "R9", "passes after reset", 64'(passes_o), 64'd0);
    chk(rdata_o == '0, "R9", "rdata after reset", 64'(|rdata_o), 64'd0);

    // fill all storage with 8-byte-mode stores; halves of one word share a pass (R4)
    for (int k = 0; k < 32; k++) begin
      run_vec(1'b1, 1'b1, 32'hFFFF_FFFF, k * 32, 1, 32, 1, "R4");
    end

    // table walk
    for (int v = 0; v < NV; v++) begin
      string rq;
      case (v)
        0, 6:              rq = "R1";
        1:                 rq = "R3";
        2, 3, 8:           rq = "R2";
        4, 5, 9, 14, 16:   rq = "R4";
        7:                 rq = "R5";
        10, 11, 12:        rq = "R6";
        default:           rq = "R10";
      endcase
      run_vec(VECS[v][65], VECS[v][64], VECS[v][63:32], int'(VECS[v][31:22]),
              int'(VECS[v][21:12]), int'(VECS[v][11:6]), int'(VECS[v][5:0]), rq);
    end

    // R8 empty request, in both modes
    run_vec(1'b0, 1'b0, 32'h0, 0, 1, 32, 0, "R8");
    run_vec(1'b1, 1'b1, 32'h0, 0, 1, 32, 0, "R8");

    // R1 bit 9 ignored in 4-byte mode: addr 512+l reads the same words as l
    run_vec(1'b0, 1'b0, 32'hFFFF_FFFF, 512, 1, 32, 1, "R1");

    // R5 single active lane among conflicting addresses
    run_vec(1'b0, 1'b0, 32'h8000_0000, 0, 32, 32, 1, "R5");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule